// File: doc/BRIEF.md
# Prioritized Latched Interrupt Controller

This block gathers five interrupt requests into sticky request latches and hands the CPU one winner at a time. Two of the requests come from external pins and are captured on a high-to-low transition. The other three are single-cycle pulses from on-chip logic: timer 1 overflow, timer 2 overflow and an interval tick. A master enable and a 4-bit per-source enable register decide which latched requests may be taken. The first external request is gated only by the master enable. One enable bit covers both timer 2 and the interval tick.

The CPU strobes `instr_end` at each instruction boundary. If an eligible request is pending at that edge, the block accepts the highest-priority one. It raises `ack` for one clock and presents the vector index. The `ack` pulse tells the CPU to save PC and flags and to force its status flag to 1. In the same edge the block clears the master enable and the winner's latch. It then holds `busy` for the two-instruction-cycle entry sequence.

Software can clear latches through a keep-mask command, in which a 0 bit clears that latch. The same command can also set or clear the master enable. Software has no way to set a latch. A return strobe sets the master enable again.

Top module: `prio_intc`

## Requirements
- R1: An internal pulse (`tmr1_ovf`, `tmr2_ovf`, `tick`) high at a clock edge sets its latch at that edge. The latch holds until it is accepted or cleared by command.
- R2: A high-to-low transition on `ext_n[0]` or `ext_n[1]` sets that source's latch within SYNC_STAGES+1 clocks. A pin held steadily low, or a low-to-high transition, sets nothing.
- R3: Enable register mapping: bit 0 gates external 2, bit 1 gates both timer 2 and the tick, bit 2 gates timer 1, and bit 3 is stored but gates nothing. External 1 ignores the register. A write with `en_wr` appears on `en_rdata` one clock later.
- R4: Priority, highest first, with vector index: external 1 = 0, external 2 = 1, timer 1 = 2, timer 2 = 3, tick = 4.
- R5: Acceptance happens at an edge where all of the following hold: `instr_end` is high, the master enable is 1, `busy` is 0, and an eligible latch is set. After that edge, `ack` is 1 for exactly one clock and `ack_vec` holds the winner's index. At the same edge `mie` becomes 0 and only the winner's latch is cleared.
- R6: After an acceptance `busy` stays high for ACK_LEN clocks, and no new acceptance occurs while it is high.
- R7: A command with `cmd_valid` clears every latch whose `cmd_keep` bit is 0 and leaves every latch whose bit is 1 unchanged. Bit order follows R4. `cmd_mie_set` sets and `cmd_mie_clr` clears the master enable.
- R8: A request arriving at the same edge as a command or acceptance clear of its latch wins, so the latch stays set.
- R9: `reti` sets the master enable. A set (from `reti` or a command) beats a command clear at the same edge. An acceptance at that edge leaves it cleared.
- R10: Synchronous reset clears the master enable, the enable register, all latches, `ack` and `busy`.
- R11: While the master enable is 0, no acceptance occurs, and pending latches are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n | input | 2 | External request pins, falling edge active |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| tick | input | 1 | Interval timer pulse |
| instr_end | input | 1 | Instruction boundary strobe |
| en_wr | input | 1 | Enable register write |
| en_wdata | input | 4 | Enable register write data |
| en_rdata | output | 4 | Enable register contents |
| cmd_valid | input | 1 | Latch-clear command strobe |
| cmd_keep | input | 5 | Keep mask, 0 clears the latch |
| cmd_mie_set | input | 1 | Command sets master enable |
| cmd_mie_clr | input | 1 | Command clears master enable |
| reti | input | 1 | Return-from-interrupt strobe |
| mie | output | 1 | Master enable state |
| ack | output | 1 | Acceptance pulse: save PC and flags, force status flag |
| ack_vec | output | 3 | Vector index of accepted source |
| busy | output | 1 | Acceptance sequence in progress |

## Verification
Latch state has no port of its own, so any wrong latch bit shows up only at the next acceptance. There it appears as a missing `ack`, an `ack` that should not be there, or a wrong `ack_vec`, one clock after the `instr_end` edge. The sweep covers every combination of the five request bits with every enable value and compares each acceptance against the eligible set. Directed sequences then drain the latches one by one after each clear or race, so that a bit kept or lost in error is exposed by the following vector.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC  = 5;
  localparam int VEC_W = 3;
  localparam int EN_W  = 4;
  typedef enum logic [VEC_W-1:0] {
    SRC_EXT1 = 3'd0,
    SRC_EXT2 = 3'd1,
    SRC_TMR1 = 3'd2,
    SRC_TMR2 = 3'd3,
    SRC_TICK = 3'd4
  } src_e;
endpackage

// File: rtl/intc_fall_det.sv
module intc_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_n};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q[i] <= 1'b0;
      else if (set_i[i]) q[i] <= 1'b1;
      else if (clr_i[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int N  = 5,
  parameter int VW = 3
) (
  input  logic [N-1:0]  req,
  output logic          valid,
  output logic [VW-1:0] idx
);
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = VW'(i);
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int SYNC_STAGES = 2,
  parameter int ACK_LEN     = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ext_n,
  input  logic       tmr1_ovf,
  input  logic       tmr2_ovf,
  input  logic       tick,
  input  logic       instr_end,
  input  logic       en_wr,
  input  logic [3:0] en_wdata,
  output logic [3:0] en_rdata,
  input  logic       cmd_valid,
  input  logic [4:0] cmd_keep,
  input  logic       cmd_mie_set,
  input  logic       cmd_mie_clr,
  input  logic       reti,
  output logic       mie,
  output logic       ack,
  output logic [2:0] ack_vec,
  output logic       busy
);
  import intc_pkg::*;
  localparam int CNT_W = $clog2(ACK_LEN + 1);

  logic [1:0]             ext_fall;
  logic [NSRC-1:0]        req_set, req_clr, req_q, eligible, win_1h;
  logic                   win_valid, accept, mie_q, ack_q;
  logic [VEC_W-1:0]       win_idx, vec_q;
  logic [EN_W-1:0]        en_q;
  logic [CNT_W-1:0]       cnt_q;

  for (genvar p = 0; p < 2; p++) begin : g_ext
    intc_fall_det #(.STAGES(SYNC_STAGES)) u_fall (
      .clk(clk), .rst(rst), .pin_n(ext_n[p]), .fall(ext_fall[p])
    );
  end

  assign req_set = {tick, tmr2_ovf, tmr1_ovf, ext_fall[1], ext_fall[0]};

  always_comb begin
    eligible           = '0;
    eligible[SRC_EXT1] = req_q[SRC_EXT1];
    eligible[SRC_EXT2] = req_q[SRC_EXT2] & en_q[0];
    eligible[SRC_TMR1] = req_q[SRC_TMR1] & en_q[2];
    eligible[SRC_TMR2] = req_q[SRC_TMR2] & en_q[1];
    eligible[SRC_TICK] = req_q[SRC_TICK] & en_q[1];
  end

  intc_prio_pick #(.N(NSRC), .VW(VEC_W)) u_pick (
    .req(eligible), .valid(win_valid), .idx(win_idx)
  );

  assign accept = instr_end & mie_q & win_valid & (cnt_q == '0);

  always_comb begin
    win_1h = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (win_idx == VEC_W'(i)) win_1h[i] = 1'b1;
    end
  end

  assign req_clr = (cmd_valid ? ~cmd_keep : '0) | (accept ? win_1h : '0);

  intc_req_latch #(.N(NSRC)) u_latch (
    .clk(clk), .rst(rst), .set_i(req_set), .clr_i(req_clr), .q(req_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mie_q <= 1'b0;
      en_q  <= '0;
      ack_q <= 1'b0;
      vec_q <= '0;
      cnt_q <= '0;
    end else begin
      if (accept)                             mie_q <= 1'b0;
      else if (reti || (cmd_valid && cmd_mie_set)) mie_q <= 1'b1;
      else if (cmd_valid && cmd_mie_clr)      mie_q <= 1'b0;
      if (en_wr) en_q <= en_wdata;
      ack_q <= accept;
      if (accept) vec_q <= win_idx;
      if (accept)              cnt_q <= CNT_W'(ACK_LEN);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assign en_rdata = en_q;
  assign mie      = mie_q;
  assign ack      = ack_q;
  assign ack_vec  = vec_q;
  assign busy     = (cnt_q != '0);
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk,
  input logic       rst,
  input logic       instr_end,
  input logic       en_wr,
  input logic [3:0] en_wdata,
  input logic [3:0] en_rdata,
  input logic       reti,
  input logic       mie,
  input logic       ack,
  input logic [2:0] ack_vec,
  input logic       busy
);
  a_r5_ack_drops_mie: assert property (@(posedge clk) disable iff (rst)
    ack |-> !mie);
  a_r4_vec_in_range: assert property (@(posedge clk) disable iff (rst)
    ack |-> ack_vec <= 3'd4);
  a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  a_r6_busy_with_ack: assert property (@(posedge clk) disable iff (rst)
    ack |-> busy);
  a_r11_needs_mie: assert property (@(posedge clk) disable iff (rst)
    (!mie && !ack) |=> !ack);
  a_r9_reti_sets: assert property (@(posedge clk) disable iff (rst)
    ($past(reti && !rst) && !ack) |-> mie);
  a_r3_readback: assert property (@(posedge clk) disable iff (rst)
    $past(en_wr && !rst) |-> en_rdata == $past(en_wdata));
  a_r10_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!mie && en_rdata == 4'd0 && !ack && !busy));
endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rst(rst), .instr_end(instr_end), .en_wr(en_wr),
  .en_wdata(en_wdata), .en_rdata(en_rdata), .reti(reti), .mie(mie),
  .ack(ack), .ack_vec(ack_vec), .busy(busy)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ext_n = 2'b11;
  logic       tmr1_ovf = 0, tmr2_ovf = 0, tick = 0, instr_end = 0;
  logic       en_wr = 0, cmd_valid = 0, cmd_mie_set = 0, cmd_mie_clr = 0, reti = 0;
  logic [3:0] en_wdata = 0;
  logic [4:0] cmd_keep = 5'h1f;
  logic [3:0] en_rdata;
  logic       mie, ack, busy;
  logic [2:0] ack_vec;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rst(rst), .ext_n(ext_n), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf),
    .tick(tick), .instr_end(instr_end), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_rdata(en_rdata), .cmd_valid(cmd_valid), .cmd_keep(cmd_keep),
    .cmd_mie_set(cmd_mie_set), .cmd_mie_clr(cmd_mie_clr), .reti(reti),
    .mie(mie), .ack(ack), .ack_vec(ack_vec), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_en(input logic [3:0] v);
    @(negedge clk); en_wr = 1; en_wdata = v;
    @(negedge clk); en_wr = 0;
  endtask

  task automatic cmd(input logic [4:0] keep, input bit s, input bit c);
    @(negedge clk); cmd_valid = 1; cmd_keep = keep; cmd_mie_set = s; cmd_mie_clr = c;
    @(negedge clk); cmd_valid = 0; cmd_keep = 5'h1f; cmd_mie_set = 0; cmd_mie_clr = 0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1;
    @(negedge clk); reti = 0;
  endtask

  // inject sources by request bit order ext1,ext2,tmr1,tmr2,tick
  task automatic inject(input logic [4:0] p);
    @(negedge clk);
    ext_n = ~p[1:0];
    tmr1_ovf = p[2]; tmr2_ovf = p[3]; tick = p[4];
    @(negedge clk);
    tmr1_ovf = 0; tmr2_ovf = 0; tick = 0;
    idle(3);
    ext_n = 2'b11;
    idle(4);
  endtask

  // strobe boundary; ack sampled one clock later
  task automatic boundary(output bit a, output int v);
    @(negedge clk); instr_end = 1;
    @(negedge clk); instr_end = 0;
    a = ack; v = ack_vec;
    if (a) idle(20);
  endtask

  function automatic int expect_win(input logic [4:0] p, input logic [3:0] e);
    logic [4:0] el;
    el = {p[4] & e[1], p[3] & e[1], p[2] & e[2], p[1] & e[0], p[0]};
    for (int i = 0; i < 5; i++) if (el[i]) return i;
    return -1;
  endfunction

  initial begin
    bit a; int v; int w;
    idle(3);
    rst = 0;
    idle(1);
    // R10 reset state
    chk(!mie, "R10 mie", mie, 0);
    chk(en_rdata == 0, "R10 en", en_rdata, 0);
    chk(!ack && !busy, "R10 ack/busy", ack + 2*busy, 0);

    // R11 no acceptance while master enable is 0; R1 latch persists
    inject(5'b00001);
    boundary(a, v);
    chk(!a, "R11 no ack with mie=0", a, 0);
    cmd(5'h1f, 1, 0);
    boundary(a, v);
    chk(a && v == 0, "R1 R5 held ext1 accepted vec", a ? v : -1, 0);
    chk(!mie, "R5 mie cleared", mie, 0);

    // R3 readback
    wr_en(4'b1010);
    chk(en_rdata == 4'b1010, "R3 readback", en_rdata, 10);

    // main sweep: R3 R4 R5
    for (int p = 0; p < 32; p++) begin
      for (int e = 0; e < 16; e++) begin
        wr_en(4'(e));
        cmd(5'h00, 1, 0);
        inject(5'(p));
        w = expect_win(5'(p), 4'(e));
        boundary(a, v);
        chk(a == (w >= 0), "R3 ack presence", a, w >= 0);
        if (w >= 0) chk(v == w, "R4 vector", v, w);
        chk(mie == (w < 0), "R5 mie after boundary", mie, w < 0);
      end
    end

    // R5 winner only cleared; R9 reti; R6 busy blocks
    wr_en(4'b0110);
    cmd(5'h00, 1, 0);
    inject(5'b01100);
    @(negedge clk); instr_end = 1;
    @(negedge clk); instr_end = 0;
    chk(ack && ack_vec == 2, "R5 first tmr1", ack_vec, 2);
    do_reti();
    chk(mie, "R9 reti sets mie", mie, 1);
    chk(busy, "R6 busy held", busy, 1);
    @(negedge clk); instr_end = 1;
    @(negedge clk); instr_end = 0;
    chk(!ack, "R6 no accept while busy", ack, 0);
    idle(20);
    boundary(a, v);
    chk(a && v == 3, "R5 other latch kept", a ? v : -1, 3);
    do_reti();
    boundary(a, v);
    chk(!a, "R5 latches drained", a, 0);

    // R7 keep mask
    wr_en(4'b0111);
    cmd(5'h00, 1, 0);
    inject(5'b11100);
    cmd(5'b10111, 0, 0);
    boundary(a, v);
    chk(a && v == 2, "R7 kept tmr1", a ? v : -1, 2);
    do_reti();
    boundary(a, v);
    chk(a && v == 4, "R7 tmr2 cleared, tick kept", a ? v : -1, 4);
    do_reti();
    cmd(5'h1f, 0, 1);
    chk(!mie, "R7 cmd clears mie", mie, 0);

    // R8 set beats clear
    cmd(5'h00, 1, 0);
    @(negedge clk); cmd_valid = 1; cmd_keep = 5'h00; tmr2_ovf = 1;
    @(negedge clk); cmd_valid = 0; cmd_keep = 5'h1f; tmr2_ovf = 0;
    boundary(a, v);
    chk(a && v == 3, "R8 request wins over clear", a ? v : -1, 3);

    // R9 set beats clear; acceptance beats reti
    cmd(5'h1f, 1, 1);
    chk(mie, "R9 set beats clear", mie, 1);
    cmd(5'h00, 0, 0);
    inject(5'b00100);
    @(negedge clk); instr_end = 1; reti = 1;
    @(negedge clk); instr_end = 0; reti = 0;
    chk(ack && !mie, "R9 accept beats reti", mie, 0);
    idle(20);

    // R2 steady low and rising edge set nothing
    cmd(5'h00, 1, 0);
    @(negedge clk); ext_n = 2'b01;
    idle(6);
    cmd(5'h00, 0, 0);
    idle(3);
    ext_n = 2'b11;
    idle(6);
    wr_en(4'b1111);
    boundary(a, v);
    chk(!a, "R2 no latch on low or rise", a, 0);
    inject(5'b00010);
    boundary(a, v);
    chk(a && v == 1, "R2 fall sets ext2", a ? v : -1, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule